// File: doc/BRIEF.md
# Hash Input Byte Packer

This block sits in front of a digest engine and turns a stream of 32-bit words, written through a port that has no byte-enable mask, into a byte stream with valid, ready and last. Before a message starts, a configuration write gives a two-bit lane-order code and the total message length in bits as a 64-bit value. Each accepted word is permuted according to the order code and then handed out one byte per output handshake.

The byte count is the programmed bit length divided by eight. Since the port only carries whole words, the final word may hold lanes beyond the message end. Those lanes are dropped, so the engine sees exactly the programmed number of bytes, and the final byte carries the last flag. A word that arrives while no message is configured is consumed and thrown away, and an error pulse is raised. This covers words written before any configuration and words written after the count has run out. After a configuration write the data port holds ready low for a fixed settling window.

Top module: `hash_byte_packer`

## Requirements
- R1: After reset the block is unconfigured: `wr_ready` is 1, `out_valid` is 0 and `wr_err` is 0.
- R2: Byte order: within each word, bytes leave in this lane sequence, where lane n is `wr_data[8n+7:8n]`. Code 0 gives 0,1,2,3. Code 1 gives 3,2,1,0. Code 2 gives 0,1,3,2. Code 3 gives 2,3,0,1.
- R3: The number of bytes emitted per message equals `cfg_bits[63:3]`. Lanes of the final word beyond that count are never emitted.
- R4: `out_last` is 1 exactly on the final counted byte of a message and 0 on every other valid byte.
- R5: A word presented while unconfigured is consumed (`wr_ready` is 1), produces no output byte, and raises `wr_err` for one cycle in the following cycle.
- R6: Once the count has been reached, the block returns to the unconfigured state, so a further word raises `wr_err` as in R5.
- R7: For the GAP_CYC (default 2) cycles after a configuration write is taken, `wr_ready` is 0. It becomes 1 in the cycle after that.
- R8: While the block holds a word that still has bytes to send, `wr_ready` is 0.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values and `out_valid` stays 1.
- R10: A configuration whose byte count is zero leaves the block unconfigured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_order | input | 2 | Lane-order code (R2) |
| cfg_bits | input | 64 | Message length in bits |
| wr_valid | input | 1 | Data word offered |
| wr_data | input | 32 | Data word |
| wr_ready | output | 1 | Data word taken when high together with wr_valid |
| wr_err | output | 1 | One-cycle pulse: word discarded while unconfigured |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of message |
| out_ready | input | 1 | Engine accepts byte |

## Verification
A word taken at a clock edge shows its first byte on `out_data` right after that edge, and each later byte appears one edge after the previous one is accepted. `wr_err` rises at the same edge that swallows the stray word. `wr_ready` stays low for the two cycles that follow the edge taking a configuration write, and rises after them. The bench drives inputs and samples outputs on the falling clock edge, so each value is read half a cycle after the edge that produced it. Every check is placed at the falling edge that follows the rising edge it depends on.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int LANES = 4;
  localparam int LIDX_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } hbp_state_e;

  // Lane feeding emitted position k under a given order code.
  function automatic logic [LIDX_W-1:0] hbp_lane(input logic [1:0] order,
                                                 input logic [LIDX_W-1:0] k);
    logic [LIDX_W-1:0] r;
    case (order)
      2'd0: r = k;
      2'd1: r = LIDX_W'(LANES - 1) - k;
      2'd2: r = k[1] ? {1'b1, ~k[0]} : k;
      default: r = k ^ 2'b10;
    endcase
    return r;
  endfunction

  // Bytes taken from the next word given the bytes still owed.
  function automatic logic [2:0] hbp_take(input logic [60:0] rem);
    logic [2:0] t;
    if (rem >= 61'(LANES)) t = 3'(LANES);
    else t = rem[2:0];
    return t;
  endfunction

endpackage

// File: rtl/hbp_lane_order.sv
module hbp_lane_order
  import hbp_pkg::*;
(
  input  logic [1:0]         order,
  input  logic [8*LANES-1:0] word_in,
  output logic [8*LANES-1:0] word_out
);

  for (genvar k = 0; k < LANES; k++) begin : g_pos
    logic [LIDX_W-1:0] src;
    assign src = hbp_lane(order, LIDX_W'(k));
    assign word_out[8*k +: 8] = word_in[8*src +: 8];
  end

  // R2: the permutation touches every lane exactly once.
  always_comb begin
    logic [LANES-1:0] seen;
    seen = '0;
    for (int k = 0; k < LANES; k++) seen[hbp_lane(order, LIDX_W'(k))] = 1'b1;
    assert_perm_full_R2: assert (&seen);
  end

endmodule

// File: rtl/hbp_len_track.sv
module hbp_len_track
  import hbp_pkg::*;
#(
  parameter int LEN_W = 64,
  localparam int RW = LEN_W - 3
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] bits,
  input  logic             consume,
  output logic [2:0]       take,
  output logic             rem_zero,
  output logic             load_zero
);

  logic [RW-1:0] rem_q;

  assign load_zero = (bits[LEN_W-1:3] == '0);
  assign take      = hbp_take(61'(rem_q));
  assign rem_zero  = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) rem_q <= '0;
    else if (load) rem_q <= bits[LEN_W-1:3];
    else if (consume) rem_q <= rem_q - RW'(take);
  end

  // R3: a word is never consumed when nothing is owed.
  assert_no_underrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !load |-> !rem_zero);

endmodule

// File: rtl/hbp_byte_drain.sv
module hbp_byte_drain
  import hbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               load,
  input  logic [8*LANES-1:0] word,
  input  logic [2:0]         count,
  input  logic               pop,
  output logic               holding,
  output logic [7:0]         byte_out,
  output logic               at_end
);

  logic [8*LANES-1:0] word_q;
  logic [2:0]         cnt_q;
  logic [2:0]         idx_q;

  assign byte_out = word_q[8*idx_q[LIDX_W-1:0] +: 8];
  assign at_end   = (idx_q + 3'd1 == cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      holding <= 1'b0;
      word_q  <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else if (load) begin
      holding <= 1'b1;
      word_q  <= word;
      cnt_q   <= count;
      idx_q   <= '0;
    end else if (pop && holding) begin
      idx_q <= idx_q + 3'd1;
      if (at_end) holding <= 1'b0;
    end
  end

  // R8: a new word never lands on top of unsent bytes.
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    holding && !pop && !clear |-> !load);
  assert_count_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (count != 3'd0) && (count <= 3'(LANES)));

endmodule

// File: rtl/hash_byte_packer.sv
module hash_byte_packer
  import hbp_pkg::*;
#(
  parameter int LEN_W   = 64,
  parameter int GAP_CYC = 2,
  localparam int DW = 8 * LANES,
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_bits,
  input  logic             wr_valid,
  input  logic [DW-1:0]    wr_data,
  output logic             wr_ready,
  output logic             wr_err,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  input  logic             out_ready
);

  hbp_state_e    state_q;
  logic [1:0]    order_q;
  logic [GW-1:0] gap_q;

  logic          word_take;
  logic          stray_take;
  logic          byte_fire;
  logic          msg_end;
  logic [2:0]    take;
  logic          rem_zero;
  logic          load_zero;
  logic          holding;
  logic          at_end;
  logic [DW-1:0] ordered;

  assign wr_ready   = (state_q == ST_IDLE) || ((state_q == ST_RUN) && !holding);
  assign word_take  = wr_valid && wr_ready && (state_q == ST_RUN) && !cfg_valid;
  assign stray_take = wr_valid && wr_ready && (state_q == ST_IDLE);
  assign out_valid  = holding;
  assign out_last   = holding && at_end && rem_zero;
  assign byte_fire  = out_valid && out_ready;
  assign msg_end    = byte_fire && out_last;

  hbp_lane_order u_order (
    .order    (order_q),
    .word_in  (wr_data),
    .word_out (ordered)
  );

  hbp_len_track #(.LEN_W(LEN_W)) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_valid),
    .bits      (cfg_bits),
    .consume   (word_take),
    .take      (take),
    .rem_zero  (rem_zero),
    .load_zero (load_zero)
  );

  hbp_byte_drain u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_valid),
    .load     (word_take),
    .word     (ordered),
    .count    (take),
    .pop      (out_ready),
    .holding  (holding),
    .byte_out (out_data),
    .at_end   (at_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      order_q <= '0;
      gap_q   <= '0;
      wr_err  <= 1'b0;
    end else begin
      wr_err <= stray_take;
      if (cfg_valid) begin
        order_q <= cfg_order;
        gap_q   <= GW'(GAP_CYC);
        if (load_zero) state_q <= ST_IDLE;
        else if (GAP_CYC == 0) state_q <= ST_RUN;
        else state_q <= ST_SETTLE;
      end else begin
        case (state_q)
          ST_SETTLE: begin
            gap_q <= gap_q - GW'(1);
            if (gap_q <= GW'(1)) state_q <= ST_RUN;
          end
          ST_RUN: if (msg_end) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R5: an error pulse always follows a word that was offered.
  assert_err_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_valid));
  // R7: no data is taken just after a configuration write.
  assert_gap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_valid) && !load_zero && (GAP_CYC > 0) |-> !wr_ready);
  // R4: last only qualifies a valid byte.
  assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R9: a stalled byte stays put.
  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !cfg_valid |=> out_valid && $stable(out_data) && $stable(out_last));
  // R6: the block is unconfigured right after the final byte.
  assert_idle_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end && !cfg_valid |=> wr_ready && !out_valid);

endmodule

// File: tb/hash_byte_packer_test.sv
`timescale 1ns/1ps
module hash_byte_packer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_order = '0;
  logic [63:0] cfg_bits = '0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, wr_err, out_valid, out_last;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hash_byte_packer uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_order(cfg_order),
    .cfg_bits(cfg_bits), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .wr_err(wr_err), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lane sequences written out per code (R2).
  function automatic int lane_for(int code, int pos);
    int seq0[4] = '{0, 1, 2, 3};
    int seq1[4] = '{3, 2, 1, 0};
    int seq2[4] = '{0, 1, 3, 2};
    int seq3[4] = '{2, 3, 0, 1};
    case (code)
      0: return seq0[pos];
      1: return seq1[pos];
      2: return seq2[pos];
      default: return seq3[pos];
    endcase
  endfunction

  task automatic configure(input int code, input int nbytes, input bit zero_len);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_order = 2'(code); cfg_bits = 64'(nbytes) << 3;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (!zero_len) begin
      check(wr_ready == 1'b0, "R7 gap cycle 1", wr_ready, 0);
      @(negedge clk);
      check(wr_ready == 1'b0, "R7 gap cycle 2", wr_ready, 0);
      @(negedge clk);
      check(wr_ready == 1'b1, "R7 ready after gap", wr_ready, 1);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    int guard = 0;
    wr_valid = 1'b1; wr_data = w;
    while (!wr_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Drain the expected bytes of one word; stall inserts idle cycles.
  task automatic drain_word(input logic [31:0] w, input int code, input int nb,
                            input bit final_word, input bit stall);
    int pos = 0;
    int guard = 0;
    while (pos < nb && guard < 200) begin
      guard++;
      if (out_valid) check(wr_ready == 1'b0, "R8 ready low while holding", wr_ready, 0);
      if (stall && (guard % 3 == 1)) begin
        out_ready = 1'b0;
        if (out_valid) begin
          logic [7:0] d0 = out_data;
          @(negedge clk);
          check(out_valid && out_data == d0, "R9 byte held under stall", out_data, d0);
          continue;
        end
      end
      out_ready = 1'b1;
      if (out_valid) begin
        logic [7:0] exp_b = w[8*lane_for(code, pos) +: 8];
        bit exp_l = final_word && (pos == nb - 1);
        check(out_data == exp_b, "R2 byte value", out_data, exp_b);
        check(out_last == exp_l, "R4 last flag", out_last, exp_l);
        pos++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(pos == nb, "R3 byte count of word", pos, nb);
  endtask

  task automatic run_msg(input int code, input int nbytes, input bit stall);
    int left = nbytes;
    int wi = 0;
    configure(code, nbytes, 1'b0);
    while (left > 0) begin
      logic [31:0] w = 32'h1000_0000 * (wi + 1) + 32'h0403_0201 * (code + 1) + 32'(nbytes);
      int nb = (left >= 4) ? 4 : left;
      push_word(w);
      drain_word(w, code, nb, left <= 4, stall);
      left -= nb;
      wi++;
    end
    check(out_valid == 1'b0, "R3 no bytes past count", out_valid, 0);
    check(wr_ready == 1'b1, "R6 unconfigured after end", wr_ready, 1);
  endtask

  task automatic stray_write(input string req);
    push_word(32'hDEAD_BEEF);
    check(wr_err == 1'b1, req, wr_err, 1);
    check(out_valid == 1'b0, {req, " no output"}, out_valid, 0);
    @(negedge clk);
    check(wr_err == 1'b0, {req, " single pulse"}, wr_err, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(wr_ready == 1'b1, "R1 reset wr_ready", wr_ready, 1);
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(wr_err == 1'b0, "R1 reset wr_err", wr_err, 0);
  endtask

  task automatic test_zero_len();
    configure(1, 0, 1'b1);
    check(wr_ready == 1'b1, "R10 zero length stays idle", wr_ready, 1);
    stray_write("R10 zero length write error");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        stray_write("R5 write before config");
        run_msg(0, 8, 1'b0);
        run_msg(1, 8, 1'b0);
        run_msg(2, 8, 1'b1);
        run_msg(3, 8, 1'b0);
        run_msg(0, 6, 1'b0);
        run_msg(2, 7, 1'b1);
        run_msg(3, 5, 1'b0);
        run_msg(1, 1, 1'b0);
        stray_write("R6 write after count reached");
        test_zero_len();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule